// File: doc/BRIEF.md
# Two-Wire Serial Slave with Paged Byte Array

This block is the target side of a two-wire serial bus (SCL clock, open-drain SDA). It holds a 256-byte data array and a separate, smaller configuration register space, both built from plain registers. It recognises START and STOP conditions, decodes the slave address byte, and reaches the array through single-byte writes, page writes of up to 16 bytes, random reads, current-address reads and sequential reads.

Both bus lines are oversampled by the block clock. Each line passes through a two-stage synchroniser and a short glitch filter before any edge is seen. The block drives SDA only through `sda_oe`, a pull-low enable. After every write that stored data, a timed internal write cycle starts at STOP. During that cycle the slave acknowledges nothing, so a master can poll it until it answers.

Top module: `twi_paged_slave`

## Requirements
- R1: The address byte is read MSB first as device type in bits 7..4, then A2, A1, A0 in bits 3..1, then the direction in bit 0 (1 = read). The slave acknowledges it only when the type is valid and bits 3..1 equal `strap_addr`. Otherwise it leaves SDA released.
- R2: With `mem_alt_sel` = 0 the array answers to type 1010. With `mem_alt_sel` = 1 it answers to 1011, and 1010 gets no acknowledge. Type 1001 always selects the configuration space. Any other type gets no acknowledge.
- R3: With `any_addr_en` = 1, a valid type is acknowledged whatever bits 3..1 hold.
- R4: In a write, the byte after the address byte sets the word pointer. Each data byte is stored at the pointer, and then only the low 4 pointer bits advance. A 17th data byte therefore lands on the first location written in that 16-byte page.
- R5: A write that carries only a word address, followed by a repeated START with bit 0 = 1, reads from that address. Such an address-only write starts no write cycle.
- R6: During a read, every byte sent advances all 8 pointer bits, so location 255 is followed by location 0.
- R7: A read with no word address returns the location after the last one accessed. After a read this is the last byte sent plus one. After a write it is the last written location plus one, wrapped inside its page.
- R8: From the STOP that ends a write which stored data, for WR_CYCLES clock cycles, the slave ignores START and acknowledges no address byte. After that it acknowledges again.
- R9: When the master does not acknowledge a read byte, the slave releases SDA. It drives nothing on further SCL pulses until a STOP or START.
- R10: A pulse on SCL or SDA shorter than the filter length is ignored. The data being received is not disturbed and no START or STOP is seen.
- R11: Writes through type 1001 change only the configuration space and leave the array unchanged. The configuration space is indexed by the low 5 bits of the pointer (CFG_DEPTH = 32).
- R12: After reset, and while the bus is idle, `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_addr | input | 3 | Board-strapped A2..A0 address bits |
| any_addr_en | input | 1 | 1 = accept any A2..A0 in the address byte |
| mem_alt_sel | input | 1 | 0 = array type 1010, 1 = array type 1011 |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
The write-cycle timer and START detection can land in the same cycle. A poll can arrive exactly as the timer runs out. The bench provokes this by ending every data write with STOP and polling with address-only transactions at once and repeatedly. It records the cycle of each STOP and each START edge. It then judges that every poll refused came no later than WR_CYCLES (plus a two-cycle margin) after the STOP, and that the first poll acknowledged came no earlier than that mark.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int WORD_W = 8;

    localparam logic [3:0] DEVTYPE_MEM     = 4'b1010;
    localparam logic [3:0] DEVTYPE_MEM_ALT = 4'b1011;
    localparam logic [3:0] DEVTYPE_CFG     = 4'b1001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } twi_state_e;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_CFG = 1'b1
    } twi_space_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } twi_evt_t;

    typedef struct packed {
        logic              en;
        twi_space_e        space;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } twi_wr_t;

    function automatic logic [3:0] mem_devtype(input logic alt);
        return alt ? DEVTYPE_MEM_ALT : DEVTYPE_MEM;
    endfunction

    // advance only the low lo_bits of an address, keeping the page bits
    function automatic logic [WORD_W-1:0] page_step(input logic [WORD_W-1:0] a,
                                                    input int lo_bits);
        logic [WORD_W-1:0] m;
        m = (WORD_W'(1) << lo_bits) - WORD_W'(1);
        return (a & ~m) | ((a + WORD_W'(1)) & m);
    endfunction

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CW-1:0]          run_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // output follows only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= 1'b1;
            run_q <= '0;
        end else if (synced == dout) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_LEN - 1)) begin
            dout  <= synced;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_FILTER_HOLDS_SHORT_PULSE: assert property (@(posedge clk) disable iff (rst)
        (synced != dout && run_q == '0) |=> $stable(dout)) else $error("filter passed a one-cycle pulse"); // R10

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events
    import twi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output twi_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
        evt.sda      = sda_f;
    end

endmodule

// File: rtl/twi_reg_store.sv
module twi_reg_store
    import twi_pkg::*;
#(
    parameter int CFG_DEPTH = 32
) (
    input  logic              clk,
    input  twi_wr_t           wr,
    input  twi_space_e        rd_space,
    input  logic [WORD_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int MEM_DEPTH = 1 << WORD_W;
    localparam int CFG_AW    = $clog2(CFG_DEPTH);

    logic [WORD_W-1:0] mem_q [MEM_DEPTH];
    logic [WORD_W-1:0] cfg_q [CFG_DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) begin
            if (wr.space == SPACE_CFG) cfg_q[wr.addr[CFG_AW-1:0]] <= wr.data;
            else                       mem_q[wr.addr]             <= wr.data;
        end
    end

    assign rd_data = (rd_space == SPACE_CFG) ? cfg_q[rd_addr[CFG_AW-1:0]] : mem_q[rd_addr];

endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
    import twi_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 1500
) (
    input  logic              clk,
    input  logic              rst,
    input  twi_evt_t          evt,
    input  logic [2:0]        strap_addr,
    input  logic              any_addr_en,
    input  logic              mem_alt_sel,
    input  logic [WORD_W-1:0] rd_data,
    output twi_wr_t           wr,
    output twi_space_e        rd_space,
    output logic [WORD_W-1:0] rd_addr,
    output logic              sda_oe
);
    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int BUSY_W  = $clog2(WR_CYCLES + 1);

    twi_state_e        st_q;
    twi_space_e        space_q;
    logic [WORD_W-1:0] shreg_q;
    logic [WORD_W-1:0] ptr_q;
    logic [3:0]        bitcnt_q;
    logic              rw_q;
    logic              mack_q;
    logic              wr_pending_q;
    logic [BUSY_W-1:0] busy_q;
    logic              busy;
    logic              type_ok;
    logic              addr_ok;

    assign busy     = (busy_q != '0);
    assign rd_addr  = ptr_q;
    assign rd_space = space_q;

    always_comb begin
        type_ok = (shreg_q[7:4] == mem_devtype(mem_alt_sel)) || (shreg_q[7:4] == DEVTYPE_CFG);
        addr_ok = any_addr_en || (shreg_q[3:1] == strap_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            space_q      <= SPACE_MEM;
            shreg_q      <= '0;
            ptr_q        <= '0;
            bitcnt_q     <= '0;
            rw_q         <= 1'b0;
            mack_q       <= 1'b0;
            wr_pending_q <= 1'b0;
            busy_q       <= '0;
            sda_oe       <= 1'b0;
            wr           <= '0;
        end else begin
            wr.en <= 1'b0;
            if (busy) busy_q <= busy_q - 1'b1;

            if (evt.stop) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
                if (wr_pending_q && !busy) busy_q <= BUSY_W'(WR_CYCLES);
                wr_pending_q <= 1'b0;
            end else if (evt.start) begin
                if (!busy) begin
                    st_q     <= ST_DEV;
                    bitcnt_q <= '0;
                    sda_oe   <= 1'b0;
                end
            end else begin
                unique case (st_q)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (evt.scl_rise) begin
                            shreg_q  <= {shreg_q[6:0], evt.sda};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (evt.scl_fall && bitcnt_q == 4'd8) begin
                            bitcnt_q <= '0;
                            if (st_q == ST_DEV) begin
                                if (type_ok && addr_ok) begin
                                    sda_oe  <= 1'b1;
                                    rw_q    <= shreg_q[0];
                                    space_q <= (shreg_q[7:4] == DEVTYPE_CFG) ? SPACE_CFG : SPACE_MEM;
                                    st_q    <= ST_DEV_ACK;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else if (st_q == ST_WADDR) begin
                                ptr_q  <= shreg_q;
                                sda_oe <= 1'b1;
                                st_q   <= ST_WADDR_ACK;
                            end else begin
                                wr.en        <= 1'b1;
                                wr.space     <= space_q;
                                wr.addr      <= ptr_q;
                                wr.data      <= shreg_q;
                                ptr_q        <= page_step(ptr_q, PAGE_AW);
                                wr_pending_q <= 1'b1;
                                sda_oe       <= 1'b1;
                                st_q         <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            if (st_q == ST_DEV_ACK && rw_q) begin
                                shreg_q <= rd_data;
                                ptr_q   <= ptr_q + 1'b1;
                                sda_oe  <= ~rd_data[7];
                                st_q    <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                st_q   <= (st_q == ST_DEV_ACK) ? ST_WADDR : ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_rise) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt_q == 4'd8) begin
                                sda_oe   <= 1'b0;
                                bitcnt_q <= '0;
                                st_q     <= ST_RACK;
                            end else begin
                                sda_oe  <= ~shreg_q[6];
                                shreg_q <= {shreg_q[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            mack_q <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack_q) begin
                                shreg_q <= rd_data;
                                ptr_q   <= ptr_q + 1'b1;
                                sda_oe  <= ~rd_data[7];
                                st_q    <= ST_RDATA;
                            end else begin
                                st_q <= ST_WAIT_STOP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_ONLY_ACK_OR_READ: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (st_q inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA})) else $error("SDA driven outside ack or read"); // R1
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe) else $error("SDA driven in write cycle"); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (busy && evt.start) |=> (st_q == ST_IDLE)) else $error("START taken in write cycle"); // R8
    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (ptr_q[WORD_W-1:PAGE_AW] == wr.addr[WORD_W-1:PAGE_AW]) &&
                  (ptr_q[PAGE_AW-1:0] == PAGE_AW'(wr.addr[PAGE_AW-1:0] + 1'b1))) else $error("page pointer left page"); // R4
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RDATA && $past(st_q) != ST_RDATA) |-> (ptr_q == $past(ptr_q) + 1'b1)) else $error("read pointer not advanced"); // R6
    AST_NACK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT_STOP) |-> !sda_oe) else $error("SDA driven after master NACK"); // R9

endmodule

// File: rtl/twi_paged_slave.sv
module twi_paged_slave
    import twi_pkg::*;
#(
    parameter int FILT_LEN   = 3,
    parameter int PAGE_BYTES = 16,
    parameter int CFG_DEPTH  = 32,
    parameter int WR_CYCLES  = 1500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_addr,
    input  logic       any_addr_en,
    input  logic       mem_alt_sel,
    output logic       sda_oe
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    twi_evt_t           evt;
    twi_wr_t            wr;
    twi_space_e         rd_space;
    logic [WORD_W-1:0]  rd_addr;
    logic [WORD_W-1:0]  rd_data;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twi_glitch_filter #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(clean_lines[g])
        );
    end

    twi_bus_events u_events (
        .clk  (clk),
        .rst  (rst),
        .scl_f(clean_lines[1]),
        .sda_f(clean_lines[0]),
        .evt  (evt)
    );

    twi_slave_fsm #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .strap_addr (strap_addr),
        .any_addr_en(any_addr_en),
        .mem_alt_sel(mem_alt_sel),
        .rd_data    (rd_data),
        .wr         (wr),
        .rd_space   (rd_space),
        .rd_addr    (rd_addr),
        .sda_oe     (sda_oe)
    );

    twi_reg_store #(.CFG_DEPTH(CFG_DEPTH)) u_store (
        .clk     (clk),
        .wr      (wr),
        .rd_space(rd_space),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/tb_twi_paged_slave.sv
`timescale 1ns/100ps
module tb_twi_paged_slave;

    localparam int Q  = 8;      // quarter bus period in clocks
    localparam int WR = 1500;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
    logic any_en = 1'b0, alt = 1'b0;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    twi_paged_slave #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .strap_addr(STRAP), .any_addr_en(any_en), .mem_alt_sel(alt), .sda_oe(sda_oe)
    );

    always #2.5 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0, fails = 0;
    bit done = 0;
    int unsigned stop_cyc = 0;

    logic [7:0] ref_mem [256];
    bit         mem_known [256];
    logic [7:0] ref_cfg [32];
    bit         cfg_known [32];
    logic [7:0] ref_ptr = 8'h00;
    logic [7:0] wbuf [32];
    int         wg [32];

    function automatic logic [3:0] cur_type();
        return alt ? 4'b1011 : 4'b1010;
    endfunction

    function automatic logic [7:0] in_page(input logic [7:0] b, input int i);
        return {b[7:4], 4'(b[3:0] + 4'(i))};
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, input int g, output logic s);
        sda_m = b;
        if (g == 1) begin wq(3); scl = 1'b1; wq(1); scl = 1'b0; wq(Q - 4); end
        else wq(Q);
        scl = 1'b1;
        if (g == 2) begin wq(3); sda_m = 1'b0; wq(1); sda_m = 1'b1; wq(Q - 4); end
        else wq(Q);
        s = sda_line;
        wq(Q);
        scl = 1'b0;
        wq(Q);
    endtask

    task automatic start_c(output int unsigned t);
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; t = cyc; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; stop_cyc = cyc; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int g, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], (i == 4) ? g : 0, s);
        clk_bit(1'b1, 0, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, 0, s); d[i] = s; end
        clk_bit(nack, 0, s);
    endtask

    task automatic compare(input logic [3:0] t, input logic [7:0] ad, input logic [7:0] d, input string req);
        if (t == 4'b1001) begin
            if (cfg_known[ad[4:0]]) check(d == ref_cfg[ad[4:0]], req, d, ref_cfg[ad[4:0]]);
        end else if (mem_known[ad]) begin
            check(d == ref_mem[ad], req, d, ref_mem[ad]);
        end
    endtask

    // polls with address-only writes until acknowledged; judges the timing against the STOP
    task automatic wait_ready();
        int unsigned ws, t0, ack_t;
        int nacks;
        bit got, late;
        logic a;
        ws = stop_cyc; nacks = 0; got = 0; late = 0; ack_t = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            start_c(t0);
            send_byte({cur_type(), STRAP, 1'b0}, 0, a);
            stop_c();
            if (a) begin got = 1; ack_t = t0; end
            else begin nacks++; if (t0 > ws + WR + 2) late = 1; end
        end
        check(got && nacks > 0, "R8 busy then ready", nacks, 1);
        check(ack_t + 2 >= ws + WR, "R8 ack too early", ack_t - ws, WR);
        check(!late, "R8 refused after timer", late, 0);
    endtask

    task automatic blk_write(input logic [3:0] t, input logic [7:0] base, input int n, input string req);
        int unsigned tt;
        logic a;
        bit ok;
        logic [7:0] ad;
        ok = 1;
        start_c(tt);
        send_byte({t, STRAP, 1'b0}, 0, a); ok &= a;
        send_byte(base, 0, a); ok &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], wg[i], a); ok &= a;
            ad = in_page(base, i);
            if (t == 4'b1001) begin ref_cfg[ad[4:0]] = wbuf[i]; cfg_known[ad[4:0]] = 1; end
            else begin ref_mem[ad] = wbuf[i]; mem_known[ad] = 1; end
        end
        stop_c();
        check(ok, req, ok, 1);
        ref_ptr = in_page(base, n);
        if (n > 0) wait_ready();
    endtask

    task automatic rand_read(input logic [3:0] t, input logic [2:0] p, input logic [7:0] base,
                             input int n, input string req);
        int unsigned tt;
        logic a1, a2, a3;
        logic [7:0] d;
        start_c(tt);
        send_byte({t, p, 1'b0}, 0, a1);
        send_byte(base, 0, a2);
        start_c(tt);
        send_byte({t, p, 1'b1}, 0, a3);
        check(a1 && a2 && a3, req, {a1, a2, a3}, 7);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            compare(t, base + 8'(i), d, req);
        end
        stop_c();
        ref_ptr = base + 8'(n);
    endtask

    task automatic cur_read(input int n, input string req);
        int unsigned tt;
        logic a;
        logic [7:0] d;
        start_c(tt);
        send_byte({cur_type(), STRAP, 1'b1}, 0, a);
        check(a, req, a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            compare(cur_type(), ref_ptr + 8'(i), d, req);
        end
        stop_c();
        ref_ptr = ref_ptr + 8'(n);
    endtask

    task automatic addr_probe(input logic [3:0] t, input logic [2:0] p, input logic exp, input string req);
        int unsigned tt;
        logic a;
        start_c(tt);
        send_byte({t, p, 1'b0}, 0, a);
        stop_c();
        check(a == exp, req, a, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unsigned tt;
        logic a, s, all_high;
        logic [7:0] d, base;
        int n;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) wg[i] = 0;
        wq(10);
        rst = 1'b0;
        wq(5);
        check(sda_oe == 1'b0, "R12 reset", sda_oe, 0);
        wq(40);
        check(sda_oe == 1'b0, "R12 idle", sda_oe, 0);

        // R1 strap match; R5 address-only write leaves no write cycle
        addr_probe(4'b1010, 3'b100, 1'b0, "R1 wrong strap");
        start_c(tt);
        send_byte({4'b1010, STRAP, 1'b0}, 0, a); check(a, "R1 match", a, 1);
        send_byte(8'h00, 0, a); check(a, "R1 word addr", a, 1);
        stop_c();
        addr_probe(4'b1010, STRAP, 1'b1, "R5 no write cycle");
        addr_probe(4'b1100, STRAP, 1'b0, "R2 bad type");

        // fill two pages
        for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
        blk_write(4'b1010, 8'h00, 16, "R4 page 00");
        for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
        blk_write(4'b1010, 8'hF0, 16, "R4 page F0");

        // R4 17-byte page write wraps; R7 current address after write
        for (int i = 0; i < 17; i++) wbuf[i] = 8'($urandom);
        blk_write(4'b1010, 8'h35, 17, "R4 wrap write");
        cur_read(1, "R7 after write");
        rand_read(4'b1010, STRAP, 8'h30, 16, "R4 wrap readback");

        // R7 after a read; R5 random read
        rand_read(4'b1010, STRAP, 8'h00, 3, "R5 random read");
        cur_read(2, "R7 after read");

        // R6 full 8-bit rollover
        rand_read(4'b1010, STRAP, 8'hFE, 4, "R6 rollover");

        // R9 master NACK ends the read
        start_c(tt);
        send_byte({4'b1010, STRAP, 1'b0}, 0, a);
        send_byte(8'h00, 0, a);
        start_c(tt);
        send_byte({4'b1010, STRAP, 1'b1}, 0, a);
        recv_byte(1'b1, d);
        compare(4'b1010, 8'h00, d, "R9 data");
        all_high = 1'b1;
        for (int i = 0; i < 9; i++) begin clk_bit(1'b1, 0, s); all_high &= s; end
        check(all_high, "R9 silent after NACK", all_high, 1);
        stop_c();
        ref_ptr = 8'h01;
        cur_read(1, "R9 pointer after NACK");

        // R2 alternate array type
        alt = 1'b1;
        addr_probe(4'b1010, STRAP, 1'b0, "R2 1010 refused in alt");
        rand_read(4'b1011, STRAP, 8'hF0, 2, "R2 1011 read");
        alt = 1'b0;

        // R3 respond to any strap
        any_en = 1'b1;
        rand_read(4'b1010, 3'b010, 8'h00, 2, "R3 any address");
        any_en = 1'b0;
        addr_probe(4'b1010, 3'b010, 1'b0, "R3 off again");

        // R11 configuration space
        for (int i = 0; i < 2; i++) wbuf[i] = 8'($urandom);
        blk_write(4'b1001, 8'h15, 2, "R11 cfg write");
        rand_read(4'b1001, STRAP, 8'h35, 2, "R11 cfg alias read");
        rand_read(4'b1010, STRAP, 8'h35, 2, "R11 array untouched");

        // R10 glitches on both lines during a '1' bit
        wbuf[0] = 8'hD5; wg[0] = 1;
        wbuf[1] = 8'h9B; wg[1] = 2;
        blk_write(4'b1010, 8'h80, 2, "R10 glitch write");
        wg[0] = 0; wg[1] = 0;
        rand_read(4'b1010, STRAP, 8'h80, 2, "R10 glitch readback");

        // random page writes with readback of the whole page
        for (int r = 0; r < 4; r++) begin
            base = 8'($urandom);
            n = 1 + int'($urandom % 16);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            blk_write(4'b1010, base, n, "R4 random write");
            rand_read(4'b1010, STRAP, {base[7:4], 4'h0}, 16, "R4 random readback");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule